// File: doc/BRIEF.md
# Dual-Channel UART Baud Clock Generator

This block makes the transmit and receive bit clocks for a UART from a single control byte. A shared prescaler produces a one-cycle tick. The tick comes either from a power-of-two division of the system clock or from rising edges on an external clock pin. Each of the two channels counts ticks up to a programmed modulus. Every time the count completes, the channel's output flips. The result is a symmetric clock whose period is twice the count length.

Each channel runs only while its enable input is high. With its enable low, a channel holds its counter and output at zero. Any write of the control byte restarts the prescaler, both counters and both outputs, so that the new settings start from a known phase. All logic is clocked by the system clock, and the prescaler output is a clock enable, not a derived clock.

Top module: `baud_clkgen`

## Requirements
- R1: After reset both clock outputs are low and the control byte is zero.
- R2: Control byte fields: bits 6:4 are the source select and bits 3:0 the modulus M. Bit 7 has no effect on the outputs.
- R3: Select codes 0 to 6 make one tick every 2^(code+1) system clocks, counted from the write edge: the n-th tick takes effect at edge W+n*D, where D=2^(code+1) and W is the write edge.
- R4: Select code 7 makes one tick per rising edge of ext_clk. The pin is synchronised to the system clock before use. With ext_clk period P cycles, the outputs toggle every (M+1)*P cycles.
- R5: A channel's counter returns to zero on the tick that finds it equal to M, and its output flips on that tick. With a divided source, the output therefore toggles at edges W+k*(M+1)*D for k=1,2,3,...
- R6: A write to the control byte clears both counters and both outputs. Both outputs are low in the cycle after the write edge.
- R7: While a channel's enable is low, its counter and output are held at zero. Its output is low in the cycle after the enable falls.
- R8: The channels are independent. A disabled channel stays low while the other runs, and disabling one channel does not stop the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte: select in 6:4, modulus in 3:0 |
| ext_clk | input | 1 | External tick source, asynchronous |
| tx_en | input | 1 | Transmit channel enable |
| rx_en | input | 1 | Receive channel enable |
| tx_clk | output | 1 | Transmit bit clock |
| rx_clk | output | 1 | Receive bit clock |

## Verification
The bench builds the block with its default parameters: a 3-bit select, a 4-bit modulus and 5-bit channel counters. These values reach every divided source up to divide-by-128, the moduli 0 and 15, and the external source. Expected toggle cycles are derived from the write edge for each channel and compared edge by edge. This exposes off-by-one errors in the prescaler mask, in the match compare and in the restart on write. Enable gating and channel independence are checked at the outputs.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int SEL_W   = 3;
  localparam int MOD_W   = 4;
  localparam int CNT_W   = 5;
  localparam int CTRL_W  = 8;
  localparam int NUM_CH  = 2;
  localparam int CH_TX   = 0;
  localparam int CH_RX   = 1;
endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int SEL_W = baud_pkg::SEL_W
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  input  logic             ext_clk,
  output logic             tick
);
  localparam int PRE_W   = (1 << SEL_W) - 1;
  localparam int EXT_SEL = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [2:0]       sync_q, sync_d;
  logic [PRE_W-1:0] mask;
  logic             ext_rise;

  always_comb begin
    mask = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i <= int'(sel)) mask[i] = 1'b1;
    end
  end

  assign ext_rise = sync_q[1] & ~sync_q[2];

  always_comb begin
    pre_d  = restart ? '0 : pre_q + 1'b1;
    sync_d = {sync_q[1:0], ext_clk};
    if (int'(sel) == EXT_SEL) tick = ext_rise;
    else                      tick = ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      sync_q <= '0;
    end else begin
      pre_q  <= pre_d;
      sync_q <= sync_d;
    end
  end

  // R3/R4: a tick never lasts two cycles unless a write intervenes
  assert_tick_single_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick && !restart) |=> !tick);
endmodule

// File: rtl/baud_channel.sv
module baud_channel #(
  parameter int MOD_W = baud_pkg::MOD_W,
  parameter int CNT_W = baud_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             tick,
  input  logic             en,
  input  logic             clr,
  input  logic [MOD_W-1:0] modulus,
  output logic             bit_clk
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tog_q, tog_d;
  logic [CNT_W-1:0] limit;
  logic             at_limit;

  assign limit    = CNT_W'(modulus);
  assign at_limit = (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    tog_d = tog_q;
    if (clr || !en) begin
      cnt_d = '0;
      tog_d = 1'b0;
    end else if (tick) begin
      if (at_limit) begin
        cnt_d = '0;
        tog_d = ~tog_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tog_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tog_q <= tog_d;
    end
  end

  assign bit_clk = tog_q;

  // R5: the count never runs past the modulus
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= limit);

  // R5: a running output only flips on a tick that found the count at the modulus
  assert_flip_on_match_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(en) && !$past(clr) && !$stable(tog_q)) |->
      ($past(tick) && $past(cnt_q) == $past(limit)));

  // R7: a disabled channel is held at zero
  assert_hold_zero_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    !en |=> (cnt_q == '0 && !tog_q));
endmodule

// File: rtl/baud_clkgen.sv
module baud_clkgen #(
  parameter int SEL_W  = baud_pkg::SEL_W,
  parameter int MOD_W  = baud_pkg::MOD_W,
  parameter int CNT_W  = baud_pkg::CNT_W,
  parameter int CTRL_W = baud_pkg::CTRL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              ext_clk,
  input  logic              tx_en,
  input  logic              rx_en,
  output logic              tx_clk,
  output logic              rx_clk
);
  localparam int NCH   = baud_pkg::NUM_CH;
  localparam int FLD_W = SEL_W + MOD_W;

  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  logic [FLD_W-1:0] ctrl_q, ctrl_d;
  logic             tick;
  logic [NCH-1:0]   ch_en;
  logic [NCH-1:0]   ch_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = wr_data[FLD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  baud_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .restart (wr_en),
    .sel     (ctrl_q[FLD_W-1:MOD_W]),
    .ext_clk (ext_clk),
    .tick    (tick)
  );

  assign ch_en[baud_pkg::CH_TX] = tx_en;
  assign ch_en[baud_pkg::CH_RX] = rx_en;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    baud_channel #(.MOD_W(MOD_W), .CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_ni  (rst_ni),
      .tick    (tick),
      .en      (ch_en[g]),
      .clr     (wr_en),
      .modulus (ctrl_q[MOD_W-1:0]),
      .bit_clk (ch_clk[g])
    );
  end

  assign tx_clk = ch_clk[baud_pkg::CH_TX];
  assign rx_clk = ch_clk[baud_pkg::CH_RX];

  // R6: a write leaves both outputs low in the following cycle
  assert_write_restart_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en |=> (!tx_clk && !rx_clk));

  // R2: the modulus field follows the written byte
  assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en |=> ctrl_q[MOD_W-1:0] == $past(wr_data[MOD_W-1:0]));
endmodule

// File: tb/baud_clkgen_test.sv
module baud_clkgen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic ext_clk = 1'b0;
  logic tx_en = 1'b0;
  logic rx_en = 1'b0;
  logic tx_clk, rx_clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int q_tx[$];
  int q_rx[$];
  bit armed = 1'b0;
  logic prev_tx, prev_rx;
  bit ext_run = 1'b0;
  int ext_cnt = 0;
  int wcyc;

  always #2.5 clk = ~clk;

  baud_clkgen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ext_clk(ext_clk), .tx_en(tx_en), .rx_en(rx_en),
    .tx_clk(tx_clk), .rx_clk(rx_clk)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (ext_run) begin
      ext_cnt = ext_cnt + 1;
      if (ext_cnt == 4) begin
        ext_cnt = 0;
        ext_clk = ~ext_clk;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pop expected toggle cycles as outputs change
  always @(negedge clk) begin
    if (armed) begin
      if (tx_clk !== prev_tx) begin
        if (q_tx.size() == 0) check(1'b0, "R5 tx unexpected toggle", cyc, -1);
        else begin
          int e;
          e = q_tx.pop_front();
          check(cyc == e, "R5 tx toggle cycle", cyc, e);
        end
        prev_tx = tx_clk;
      end
      if (rx_clk !== prev_rx) begin
        if (q_rx.size() == 0) check(1'b0, "R8 rx unexpected toggle", cyc, -1);
        else begin
          int e;
          e = q_rx.pop_front();
          check(cyc == e, "R5 rx toggle cycle", cyc, e);
        end
        prev_rx = rx_clk;
      end
    end
  end

  task automatic write_ctrl(input logic [7:0] v);
    @(negedge clk);
    wr_data = v;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    wcyc = cyc;
    check(tx_clk == 1'b0 && rx_clk == 1'b0, "R6 outputs low after write",
          {tx_clk, rx_clk}, 0);
  endtask

  // driver: write settings, push expected toggles, wait for the monitor to drain
  task automatic run_case(input bit te, input bit re, input logic [7:0] v, input int k);
    int d, m, waited;
    d = 1 << (int'(v[6:4]) + 1);
    m = int'(v[3:0]);
    tx_en = te;
    rx_en = re;
    write_ctrl(v);
    prev_tx = tx_clk;
    prev_rx = rx_clk;
    for (int n = 1; n <= k; n++) begin
      if (te) q_tx.push_back(wcyc + n * (m + 1) * d);
      if (re) q_rx.push_back(wcyc + n * (m + 1) * d);
    end
    armed = 1'b1;
    waited = 0;
    while ((q_tx.size() != 0 || q_rx.size() != 0) && waited < 40000) begin
      @(negedge clk);
      waited++;
    end
    armed = 1'b0;
    check(q_tx.size() == 0 && q_rx.size() == 0, "R3 expected toggles missing",
          q_tx.size() + q_rx.size(), 0);
    if (!te) check(tx_clk == 1'b0, "R8 disabled tx stays low", tx_clk, 0);
    if (!re) check(rx_clk == 1'b0, "R8 disabled rx stays low", rx_clk, 0);
    q_tx.delete();
    q_rx.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(tx_clk == 1'b0 && rx_clk == 1'b0, "R1 reset outputs low", {tx_clk, rx_clk}, 0);

    // R3 R5: divide by 2, modulus 0 (boundary)
    run_case(1'b1, 1'b1, 8'h00, 6);
    // R3 R5: divide by 8, modulus 3
    run_case(1'b1, 1'b1, 8'h23, 5);
    // R2: bit 7 set has no effect; divide by 4, modulus 5
    run_case(1'b1, 1'b1, 8'h95, 5);
    // R3: divide by 128 with maximum modulus 15
    run_case(1'b1, 1'b1, 8'h6F, 3);
    // R8: receive disabled while transmit runs
    run_case(1'b1, 1'b0, 8'h12, 5);
    // R8: transmit disabled while receive runs
    run_case(1'b0, 1'b1, 8'h31, 5);

    // R7: drop tx_en while tx_clk is high; rx keeps running (R8)
    begin
      int waited, rx_changes;
      logic last_rx;
      tx_en = 1'b1;
      rx_en = 1'b1;
      write_ctrl(8'h01);
      waited = 0;
      while (tx_clk != 1'b1 && waited < 100) begin
        @(negedge clk);
        waited++;
      end
      check(tx_clk == 1'b1, "R7 tx reached high before disable", tx_clk, 1);
      tx_en = 1'b0;
      @(negedge clk);
      check(tx_clk == 1'b0, "R7 tx low after enable falls", tx_clk, 0);
      rx_changes = 0;
      last_rx = rx_clk;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (rx_clk != last_rx) rx_changes++;
        last_rx = rx_clk;
        if (tx_clk != 1'b0) rx_changes = -1000;
      end
      check(rx_changes >= 4, "R8 rx runs while tx disabled", rx_changes, 4);
    end

    // R4: external source, period 8 cycles, modulus 2 -> toggle every 24 cycles
    begin
      int t_last, n, waited;
      logic last_tx;
      ext_run = 1'b1;
      tx_en = 1'b1;
      rx_en = 1'b0;
      repeat (10) @(negedge clk);
      write_ctrl(8'h72);
      last_tx = tx_clk;
      n = 0;
      t_last = 0;
      waited = 0;
      while (n < 6 && waited < 2000) begin
        @(negedge clk);
        waited++;
        if (tx_clk != last_tx) begin
          if (n > 0) check(cyc - t_last == 24, "R4 external toggle interval",
                           cyc - t_last, 24);
          t_last = cyc;
          n++;
          last_tx = tx_clk;
        end
      end
      check(n == 6, "R4 external toggles seen", n, 6);
      ext_run = 1'b0;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule